// File: doc/BRIEF.md
# Revision Select and Configuration Trigger

This block decides which of up to four stored design revisions the readout streamer should deliver, and it starts the configuration of the downstream programmable device. The revision number comes from one of two sources. One is a pair of external select pins. The other is a revision field programmed inside the memory. A source-enable input chooses between them. The chosen number is captured whenever the configuration-start line, which is shared with the target's program input, goes from low to high. The block then presents the captured number together with the first memory block of that revision.

Each revision fills one or more whole memory blocks of fixed size. A parameter gives the block count of every revision, and the block derives the start block of each revision from those counts when reset is applied. A one-cycle command strobe from the test-port logic also starts a configuration. The block samples the current selection at once and then pulls the start line low for a fixed time. That time is counted in system clock cycles and lies inside a 300–500 ns window. While the pulse runs, further commands are ignored.

Top module: `rev_cfg_trigger`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `cf_out` is 1, `rev_latched` is 0 and `base_block` is 0.
- R2: When `pin_sel_en` is 1 the selection is `rev_pins`. When it is 0 the selection is `prog_rev`, and the pins have no effect.
- R3: `REV_BLOCKS` holds a 4-bit block count for each revision, with revision i in bits [4i+3:4i]. `base_block` equals the sum of the counts of all revisions numbered below `rev_latched`. With the defaults (counts 1, 2, 1, 3) the start blocks are 0, 1, 3 and 4.
- R4: A low-to-high transition on `cf_in` captures the current selection into `rev_latched` within 5 cycles. A falling `cf_in`, or a change of selection without a rising edge, leaves `rev_latched` unchanged.
- R5: When a `cfg_cmd` is accepted, the selection present on that clock edge is in `rev_latched` from the next cycle on, before the pulse ends.
- R6: An accepted `cfg_cmd` drives `cf_out` low from the next cycle for exactly PULSE_NS/CLK_NS cycles. At the defaults this is 20 cycles, or 400 ns at 20 ns. `cf_out` then returns to 1.
- R7: A `cfg_cmd` that arrives while the pulse is running is ignored. The pulse length is unchanged and `rev_latched` is not resampled by it.
- R8: `cf_out` falls only on the cycle after `cfg_cmd` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rev_pins | input | 2 | External revision select pins (asynchronous) |
| pin_sel_en | input | 1 | 1: use pins, 0: use programmed field (asynchronous) |
| prog_rev | input | 2 | Internally programmed revision field |
| cfg_cmd | input | 1 | One-cycle configuration command strobe |
| cf_in | input | 1 | Readback of the configuration-start line (asynchronous) |
| cf_out | output | 1 | Drive of the configuration-start line, 0 = pull low |
| rev_latched | output | 2 | Captured revision number |
| base_block | output | BLK_W | First memory block of the captured revision |

## Verification
The hardest case to reach is a second command that lands inside a running pulse while the selection is also changing. To get there, the bench starts a pulse, moves the select pins to a new value, and lets them settle through the synchronisers. It then strikes `cfg_cmd` again partway through the pulse. The second command must neither stretch the low time nor resample `rev_latched`. The new value must appear only when the start line rises at the end. A full sweep over both selection sources and all four revisions checks the start-block arithmetic.

// File: rtl/rsel_pkg.sv
package rsel_pkg;

    localparam int NREV  = 4;
    localparam int REV_W = 2;
    localparam int CNT_W = 4;

    typedef logic [REV_W-1:0] rev_t;

    typedef enum logic {
        PL_IDLE  = 1'b0,
        PL_PULSE = 1'b1
    } pulse_st_e;

    // first block of revision r = sum of block counts of revisions below r
    function automatic logic [15:0] start_block(
        input logic [NREV*CNT_W-1:0] sizes,
        input rev_t                  r
    );
        logic [15:0] acc;
        acc = '0;
        for (int i = 0; i < NREV; i++) begin
            if (i < int'(r)) acc = acc + 16'(sizes[i*CNT_W +: CNT_W]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/rsel_sync.sv
module rsel_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rsel_latch.sv
module rsel_latch
    import rsel_pkg::*;
#(
    parameter int                    BLK_W      = 6,
    parameter logic [NREV*CNT_W-1:0] REV_BLOCKS = 16'h3121
) (
    input  logic             clk,
    input  logic             rst,
    input  rev_t             pins_s,
    input  logic             en_s,
    input  rev_t             prog_rev,
    input  logic             cf_s,
    input  logic             cmd_take,
    output rev_t             rev_o,
    output logic [BLK_W-1:0] base_o,
    output logic             rise_o
);
    logic             cf_d;
    rev_t             sel;
    logic [BLK_W-1:0] tbl [NREV];

    assign sel    = en_s ? pins_s : prog_rev;
    assign rise_o = cf_s & ~cf_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            cf_d <= 1'b1;
            for (int i = 0; i < NREV; i++) begin
                tbl[i] <= BLK_W'(start_block(REV_BLOCKS, rev_t'(i)));
            end
        end else begin
            cf_d <= cf_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rev_o  <= '0;
            base_o <= '0;
        end else if (rise_o || cmd_take) begin
            rev_o  <= sel;
            base_o <= tbl[sel];
        end
    end
endmodule

// File: rtl/rsel_pulser.sv
module rsel_pulser
    import rsel_pkg::*;
#(
    parameter int PULSE_CYC = 20,
    localparam int CW       = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic cmd,
    output logic cf_out,
    output logic take_o
);
    pulse_st_e     st;
    logic [CW-1:0] cnt;

    assign take_o = cmd && (st == PL_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= PL_IDLE;
            cnt    <= '0;
            cf_out <= 1'b1;
        end else begin
            case (st)
                PL_IDLE: if (take_o) begin
                    st     <= PL_PULSE;
                    cnt    <= CW'(PULSE_CYC - 1);
                    cf_out <= 1'b0;
                end
                PL_PULSE: if (cnt == '0) begin
                    st     <= PL_IDLE;
                    cf_out <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: st <= PL_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/rev_cfg_trigger.sv
module rev_cfg_trigger
    import rsel_pkg::*;
#(
    parameter int                    CLK_NS     = 20,
    parameter int                    PULSE_NS   = 400,
    parameter int                    BLK_W      = 6,
    parameter logic [NREV*CNT_W-1:0] REV_BLOCKS = 16'h3121
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       rev_pins,
    input  logic             pin_sel_en,
    input  logic [1:0]       prog_rev,
    input  logic             cfg_cmd,
    input  logic             cf_in,
    output logic             cf_out,
    output logic [1:0]       rev_latched,
    output logic [BLK_W-1:0] base_block
);
    localparam int PULSE_CYC = PULSE_NS / CLK_NS;
    localparam int SYNC_W    = REV_W + 2;

    logic [SYNC_W-1:0] async_in, sync_out;
    logic              cf_rise, cmd_take;

    assign async_in = {cf_in, pin_sel_en, rev_pins};

    rsel_sync #(.W(SYNC_W), .RST_VAL(SYNC_W'(1) << (SYNC_W - 1))) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (async_in),
        .q   (sync_out)
    );

    rsel_pulser #(.PULSE_CYC(PULSE_CYC)) u_pulse (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cfg_cmd),
        .cf_out (cf_out),
        .take_o (cmd_take)
    );

    rsel_latch #(.BLK_W(BLK_W), .REV_BLOCKS(REV_BLOCKS)) u_latch (
        .clk      (clk),
        .rst      (rst),
        .pins_s   (sync_out[REV_W-1:0]),
        .en_s     (sync_out[REV_W]),
        .prog_rev (prog_rev),
        .cf_s     (sync_out[SYNC_W-1]),
        .cmd_take (cmd_take),
        .rev_o    (rev_latched),
        .base_o   (base_block),
        .rise_o   (cf_rise)
    );
endmodule

// File: rtl/rev_cfg_checker.sv
module rev_cfg_checker
    import rsel_pkg::*;
#(
    parameter int                    PULSE_CYC  = 20,
    parameter int                    BLK_W      = 6,
    parameter logic [NREV*CNT_W-1:0] REV_BLOCKS = 16'h3121
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_cmd,
    input logic             cf_out,
    input logic [1:0]       rev_latched,
    input logic [BLK_W-1:0] base_block,
    input logic             cf_rise,
    input logic             cmd_take
);
    logic [15:0] low_run;

    always_ff @(posedge clk) begin
        if (rst || cf_out) low_run <= '0;
        else               low_run <= low_run + 1'b1;
    end

    p_reset_high_r1: assert property (@(posedge clk) rst |=> cf_out);

    p_base_sum_r3: assert property (@(posedge clk) disable iff (rst)
        base_block == BLK_W'(start_block(REV_BLOCKS, rev_latched)));

    p_rev_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$stable(rev_latched) |-> $past(cf_rise || cmd_take));

    p_pulse_len_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(cf_out) |-> low_run == 16'(PULSE_CYC));

    p_no_long_low_r7: assert property (@(posedge clk) disable iff (rst)
        low_run <= 16'(PULSE_CYC));

    p_fall_by_cmd_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(cf_out) |-> $past(cfg_cmd));
endmodule

bind rev_cfg_trigger rev_cfg_checker #(
    .PULSE_CYC  (PULSE_CYC),
    .BLK_W      (BLK_W),
    .REV_BLOCKS (REV_BLOCKS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_cmd     (cfg_cmd),
    .cf_out      (cf_out),
    .rev_latched (rev_latched),
    .base_block  (base_block),
    .cf_rise     (cf_rise),
    .cmd_take    (cmd_take)
);

// File: tb/sim_rev_cfg_trigger.sv
module sim_rev_cfg_trigger;
    localparam int BLK_W = 6;
    localparam int PULSE_EXP = 400 / 20;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [1:0]       rev_pins = 2'd0;
    logic             pin_sel_en = 1'b0;
    logic [1:0]       prog_rev = 2'd0;
    logic             cfg_cmd = 1'b0;
    logic             ext_n = 1'b1;
    logic             cf_in;
    logic             cf_out;
    logic [1:0]       rev_latched;
    logic [BLK_W-1:0] base_block;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    // open-drain style line: block drive and external pull both act
    assign cf_in = cf_out & ext_n;

    rev_cfg_trigger u0 (
        .clk         (clk),
        .rst         (rst),
        .rev_pins    (rev_pins),
        .pin_sel_en  (pin_sel_en),
        .prog_rev    (prog_rev),
        .cfg_cmd     (cfg_cmd),
        .cf_in       (cf_in),
        .cf_out      (cf_out),
        .rev_latched (rev_latched),
        .base_block  (base_block)
    );

    function automatic int exp_base(input int r);
        int sizes [4] = '{1, 2, 1, 3};
        int s = 0;
        for (int i = 0; i < r; i++) s += sizes[i];
        return s;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic ext_pulse;
        ext_n = 1'b0;
        wait_n(3);
        ext_n = 1'b1;
        wait_n(6);
    endtask

    // issue a command; optionally a second strike at low-cycle glitch_at
    task automatic run_cmd(input int glitch_at, output int width,
                           output int rev_first, output int rev_after);
        cfg_cmd = 1'b1;
        @(negedge clk);
        cfg_cmd = 1'b0;
        width = 0;
        rev_first = rev_latched;
        rev_after = rev_latched;
        while (!cf_out && width < 100) begin
            width++;
            if (glitch_at > 0 && width == glitch_at) cfg_cmd = 1'b1;
            else cfg_cmd = 1'b0;
            if (glitch_at > 0 && width == glitch_at + 2) rev_after = rev_latched;
            @(negedge clk);
        end
        cfg_cmd = 1'b0;
    endtask

    initial begin
        int w, rf, ra;
        wait_n(2);
        chk(cf_out == 1'b1, "R1 cf_out during reset", cf_out, 1);
        wait_n(3);
        rst = 1'b0;
        @(negedge clk);
        chk(cf_out == 1'b1, "R1 cf_out after reset", cf_out, 1);
        chk(rev_latched == 2'd0, "R1 rev after reset", rev_latched, 0);
        chk(base_block == '0, "R1 base after reset", base_block, 0);

        // R2/R3/R4 sweep: both sources, all revisions
        for (int en = 0; en < 2; en++) begin
            for (int r = 0; r < 4; r++) begin
                pin_sel_en = en[0];
                if (en == 1) begin rev_pins = r[1:0]; prog_rev = ~r[1:0]; end
                else         begin prog_rev = r[1:0]; rev_pins = ~r[1:0]; end
                wait_n(4);
                ext_pulse();
                chk(rev_latched == r[1:0], "R2 source select", rev_latched, r);
                chk(int'(base_block) == exp_base(r), "R3 start block", base_block, exp_base(r));
            end
        end

        // R4: no capture without a rising edge, none on a falling edge
        rev_pins = 2'd2;
        wait_n(10);
        chk(rev_latched == 2'd3, "R4 hold without edge", rev_latched, 3);
        ext_n = 1'b0;
        wait_n(5);
        chk(rev_latched == 2'd3, "R4 no capture on fall", rev_latched, 3);
        ext_n = 1'b1;
        wait_n(6);
        chk(rev_latched == 2'd2, "R4 capture on rise", rev_latched, 2);

        // R5/R6: command resamples, then fixed pulse
        rev_pins = 2'd1;
        wait_n(4);
        run_cmd(0, w, rf, ra);
        chk(rf == 1, "R5 resample on command", rf, 1);
        chk(w == PULSE_EXP, "R6 pulse width", w, PULSE_EXP);
        wait_n(6);
        chk(rev_latched == 2'd1, "R6 rev after pulse", rev_latched, 1);

        // R7: second command inside the pulse with a changed selection
        rev_pins = 2'd1;
        wait_n(4);
        cfg_cmd = 1'b1;
        @(negedge clk);
        cfg_cmd = 1'b0;
        rev_pins = 2'd3;
        w = 1;
        while (!cf_out && w < 100) begin
            cfg_cmd = (w == 8);
            if (w == 10) chk(rev_latched == 2'd1, "R7 no resample in pulse", rev_latched, 1);
            @(negedge clk);
            if (!cf_out) w++;
        end
        cfg_cmd = 1'b0;
        chk(w == PULSE_EXP, "R7 width unchanged", w, PULSE_EXP);
        wait_n(6);
        chk(rev_latched == 2'd3, "R4 capture at pulse end", rev_latched, 3);

        // R5 with programmed field
        pin_sel_en = 1'b0;
        prog_rev = 2'd2;
        wait_n(4);
        run_cmd(0, w, rf, ra);
        chk(rf == 2, "R5 command uses programmed field", rf, 2);
        chk(int'(base_block) == exp_base(2), "R3 base after command", base_block, exp_base(2));
        chk(w == PULSE_EXP, "R8 pulse only from command", w, PULSE_EXP);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule